// File: doc/BRIEF.md
# Serial Slave with FIFO Framing

This block is a synchronous serial slave that moves fixed-length words between an external master and local logic. The master supplies the serial clock, an active-low select and a data-in line. The slave drives data-out. The local side sees a receive FIFO it can pop, a transmit FIFO it can push, a status word and a one-cycle pulse for each received word. All serial inputs are brought into the local clock through two-flop synchronisers. The local clock must run at least four times faster than the serial clock.

Clock polarity sets the idle level of the serial clock. The leading edge is the edge that leaves the idle level, and the trailing edge is the one that returns to it. Clock phase decides both the sampling edge and how word boundaries are found:

- **Phase clear:** the slave holds a completed word until select returns high. The master must therefore pulse select for every word.
- **Phase set:** words stream back to back while select stays low.

Phase set is the mode for a command-then-response exchange. Local logic sees the command pulse, then pushes its reply in time for the next word of the same select assertion.

Top module: `serial_slave_fifo`

## Requirements
- R1: After reset, stat equals 6'b000101, sdo_oe is 0, sdo is 0 and frame_rx_pulse is 0. The stat bit positions are:
  - bit 0: receive empty
  - bit 1: receive full
  - bit 2: transmit empty
  - bit 3: transmit full
  - bit 4: underrun
  - bit 5: overrun
- R2: With cfg_cpha = 0:
  - the first data bit appears on sdo once select falls;
  - sdi is sampled on each leading edge, MSB first;
  - a completed word enters the receive FIFO only after select rises again.
- R3: With cfg_cpha = 1:
  - a new transmit word is driven on the first leading edge of each word;
  - sdi is sampled on trailing edges;
  - each word enters the receive FIFO at its last trailing edge, with select held low across consecutive words.
- R4: The idle level of the serial clock equals cfg_cpol, and the leading edge is the one that leaves that level. With cfg_cpol = 1 and cfg_cpha = 0, words are exchanged correctly.
- R5: frame_rx_pulse is high for exactly one cycle each time a word is written into the receive FIFO.
- R6: If the transmit FIFO is empty when a word starts, the slave shifts out zeros and the underrun bit (stat bit 4) becomes set and stays set.
- R7: If the receive FIFO is full when a word completes, that word is dropped, no pulse is given, and the overrun bit (stat bit 5) becomes set and stays set.
- R8: If select rises before a word is complete, the partial word is discarded and the next word starts again from bit 0.
- R9: While select is high, sdo_oe is 0 and sdo is 0. While select is low, sdo_oe is 1.
- R10: A one-cycle pulse on flag_clr clears both sticky bits.
- R11: With cfg_cpha = 1, a reply pushed in response to a frame_rx_pulse is shifted out in the very next word of the same select assertion.
- R12: The FIFOs behave as follows:
  - rx_data shows the oldest received word, and rx_pop removes it;
  - a tx_push while the transmit FIFO is full is ignored;
  - transmit words leave in push order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Phase: 0 = sample on leading edge, 1 = sample on trailing edge |
| sclk_in | input | 1 | Serial clock from master (asynchronous) |
| sel_n_in | input | 1 | Active-low select from master (asynchronous) |
| sdi | input | 1 | Serial data from master |
| sdo | output | 1 | Serial data to master |
| sdo_oe | output | 1 | Output enable for sdo; low means high-impedance |
| tx_push | input | 1 | Push tx_data into the transmit FIFO |
| tx_data | input | FRAME_W | Word to transmit |
| rx_pop | input | 1 | Remove the head of the receive FIFO |
| rx_data | output | FRAME_W | Head of the receive FIFO |
| flag_clr | input | 1 | Clear sticky underrun and overrun bits |
| stat | output | 6 | Status word (positions given in R1) |
| frame_rx_pulse | output | 1 | One-cycle pulse per received word |

## Verification
The bench builds the block with its defaults:

- FRAME_W = 8, so each word is shifted bit by bit against an MSB-first model.
- FIFO_DEPTH = 4, so the full-FIFO corners are reached within a handful of words: the receive FIFO fills and overruns on the fifth word, and a fifth transmit push is ignored.

The serial clock half period is eight local cycles. That leaves enough room after a frame pulse for the responder to pop the command and push three replies before the next leading edge, which makes the single-assertion command/response case reachable.

// File: rtl/serslv_pkg.sv
// Package: shared status layout for the serial slave.
// Assumes: consumers pack the status word MSB-first in the field order below.
package serslv_pkg;

    localparam int STAT_W = 6;

    // Status word layout (bit 5 down to bit 0).
    typedef struct packed {
        logic overrun;
        logic underrun;
        logic tx_full;
        logic tx_empty;
        logic rx_full;
        logic rx_empty;
    } serslv_stat_t;

endpackage

// File: rtl/serslv_sync.sv
// Module: serslv_sync
// Brings N asynchronous single-bit inputs into the local clock domain
// with a two-flop chain per bit.
// Assumes: each bit is independent, so there is no bus coherency requirement.
module serslv_sync #(
    parameter int               N       = 3,
    parameter logic [N-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic s1, s2;

        // Two-stage metastability filter for one bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= RST_VAL[g];
                s2 <= RST_VAL[g];
            end else begin
                s1 <= d[g];
                s2 <= s1;
            end
        end

        assign q[g] = s2;
    end

endmodule

// File: rtl/serslv_fifo.sv
// Module: serslv_fifo
// Synchronous first-word-fall-through FIFO.
// Assumes:
//   - DEPTH is a power of two, at least 2;
//   - a push while full is ignored;
//   - a pop while empty is ignored.
module serslv_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);

    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;
    logic         push_ok, pop_ok;

    // Flag and handshake decode.
    always_comb begin
        empty   = (wp == rp);
        full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        head    = mem[rp[AW-1:0]];
    end

    // Pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp[AW-1:0]] <= wdata;
    end

endmodule

// File: rtl/serslv_shifter.sv
// Module: serslv_shifter
// Serial engine: detects clock and select edges on synchronised inputs,
// shifts words in and out, and decides when a word starts and completes.
//   - Phase clear: a word starts at select fall and is handed over at
//     select rise, provided all bits arrived.
//   - Phase set: a word starts at its first leading edge and completes at
//     its last trailing edge.
// Assumes: inputs are already synchronised and the local clock is at least
// four times the serial clock.
module serslv_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         sclk_q,
    input  logic         sel_n_q,
    input  logic         sdi_q,
    input  logic [W-1:0] tx_head,
    input  logic         tx_empty,
    input  logic         rx_full,
    output logic         tx_pop,
    output logic         underrun_p,
    output logic         rx_push,
    output logic         overrun_p,
    output logic [W-1:0] rx_word,
    output logic         sdo_bit,
    output logic         active
);

    localparam int              CW       = $clog2(W + 1);
    localparam logic [CW-1:0]   CNT_FULL = CW'(W);
    localparam logic [CW-1:0]   CNT_LAST = CW'(W - 1);

    logic          sclk_d, sel_d;
    logic [CW-1:0] bit_cnt;
    logic [W-1:0]  tx_sh, rx_sh, start_word;
    logic          lead, trail, sel_fall, sel_rise;
    logic          frame_start, frame_done;

    // Edge detection and word start/complete decode.
    always_comb begin
        active      = !sel_n_q;
        lead        = active && (sclk_d == cpol) && (sclk_q != cpol);
        trail       = active && (sclk_d != cpol) && (sclk_q == cpol);
        sel_fall    = sel_d && !sel_n_q;
        sel_rise    = !sel_d && sel_n_q;
        frame_start = cpha ? (lead && (bit_cnt == '0)) : sel_fall;
        frame_done  = cpha ? (trail && (bit_cnt == CNT_LAST))
                           : (sel_rise && (bit_cnt == CNT_FULL));
        rx_word     = cpha ? {rx_sh[W-2:0], sdi_q} : rx_sh;
        start_word  = tx_empty ? '0 : tx_head;
        tx_pop      = frame_start && !tx_empty;
        underrun_p  = frame_start && tx_empty;
        rx_push     = frame_done && !rx_full;
        overrun_p   = frame_done && rx_full;
        sdo_bit     = tx_sh[W-1];
    end

    // Previous-cycle copies of clock and select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            sel_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_q;
            sel_d  <= sel_n_q;
        end
    end

    // Bit counter and shift registers for both phase settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
        end else if (sel_rise) begin
            bit_cnt <= '0;
        end else if (!cpha) begin
            if (sel_fall) begin
                tx_sh   <= start_word;
                bit_cnt <= '0;
            end else if (lead && (bit_cnt != CNT_FULL)) begin
                rx_sh   <= {rx_sh[W-2:0], sdi_q};
                bit_cnt <= bit_cnt + 1'b1;
            end else if (trail && (bit_cnt != CNT_FULL)) begin
                tx_sh   <= tx_sh << 1;
            end
        end else begin
            if (lead) begin
                tx_sh   <= (bit_cnt == '0) ? start_word : (tx_sh << 1);
            end else if (trail) begin
                rx_sh   <= rx_word;
                bit_cnt <= (bit_cnt == CNT_LAST) ? '0 : (bit_cnt + 1'b1);
            end
        end
    end

endmodule

// File: rtl/serial_slave_fifo.sv
// Module: serial_slave_fifo (top)
// Serial slave with receive and transmit FIFOs, sticky error flags and a
// received-word pulse.
// Assumes:
//   - FIFO_DEPTH is a power of two;
//   - FRAME_W is between 4 and 16;
//   - cfg_cpol and cfg_cpha change only while select is high.
module serial_slave_fifo
    import serslv_pkg::*;
#(
    parameter int FRAME_W    = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_cpol,
    input  logic               cfg_cpha,
    input  logic               sclk_in,
    input  logic               sel_n_in,
    input  logic               sdi,
    output logic               sdo,
    output logic               sdo_oe,
    input  logic               tx_push,
    input  logic [FRAME_W-1:0] tx_data,
    input  logic               rx_pop,
    output logic [FRAME_W-1:0] rx_data,
    input  logic               flag_clr,
    output logic [STAT_W-1:0]  stat,
    output logic               frame_rx_pulse
);

    logic [2:0]         sync_q;
    logic               tx_pop, tx_empty, tx_full;
    logic               rx_push, rx_empty, rx_full;
    logic               underrun_p, overrun_p, sdo_bit, active;
    logic [FRAME_W-1:0] tx_head, rx_word;
    logic               underrun_q, overrun_q, pulse_q;
    serslv_stat_t       stat_s;

    serslv_sync #(.N(3), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_in, sel_n_in, sdi}),
        .q     (sync_q)
    );

    serslv_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .wdata (tx_data),
        .pop   (tx_pop),
        .head  (tx_head),
        .empty (tx_empty),
        .full  (tx_full)
    );

    serslv_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_word),
        .pop   (rx_pop),
        .head  (rx_data),
        .empty (rx_empty),
        .full  (rx_full)
    );

    serslv_shifter #(.W(FRAME_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpol       (cfg_cpol),
        .cpha       (cfg_cpha),
        .sclk_q     (sync_q[2]),
        .sel_n_q    (sync_q[1]),
        .sdi_q      (sync_q[0]),
        .tx_head    (tx_head),
        .tx_empty   (tx_empty),
        .rx_full    (rx_full),
        .tx_pop     (tx_pop),
        .underrun_p (underrun_p),
        .rx_push    (rx_push),
        .overrun_p  (overrun_p),
        .rx_word    (rx_word),
        .sdo_bit    (sdo_bit),
        .active     (active)
    );

    // Sticky error flags and received-word pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underrun_q <= 1'b0;
            overrun_q  <= 1'b0;
            pulse_q    <= 1'b0;
        end else begin
            underrun_q <= (underrun_q && !flag_clr) || underrun_p;
            overrun_q  <= (overrun_q && !flag_clr) || overrun_p;
            pulse_q    <= rx_push;
        end
    end

    // Status assembly and serial output gating.
    always_comb begin
        stat_s.overrun  = overrun_q;
        stat_s.underrun = underrun_q;
        stat_s.tx_full  = tx_full;
        stat_s.tx_empty = tx_empty;
        stat_s.rx_full  = rx_full;
        stat_s.rx_empty = rx_empty;
        stat            = stat_s;
        sdo_oe          = active;
        sdo             = active && sdo_bit;
        frame_rx_pulse  = pulse_q;
    end

endmodule

// File: rtl/serial_slave_fifo_chk.sv
// Module: serial_slave_fifo_chk
// Property checker for serial_slave_fifo, attached with bind below.
// Assumes: stat follows the layout in serslv_pkg.
module serial_slave_fifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_rx_pulse,
    input logic       flag_clr,
    input logic [5:0] stat
);

    // R5: pulse never lasts two cycles
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_rx_pulse |=> !frame_rx_pulse);

    // R5: a pulse means the receive FIFO holds data
    a_r5_pulse_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        frame_rx_pulse |-> !stat[0]);

    // R6: underrun stays set until cleared
    a_r6_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[4] && !flag_clr) |=> stat[4]);

    // R7: overrun stays set until cleared
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[5] && !flag_clr) |=> stat[5]);

    // R7: overrun can only rise after the receive FIFO was full
    a_r7_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[5]) |-> $past(stat[1]));

endmodule

bind serial_slave_fifo serial_slave_fifo_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_rx_pulse (frame_rx_pulse),
    .flag_clr       (flag_clr),
    .stat           (stat)
);

// File: tb/sim_serial_slave_fifo.sv
`timescale 1ns/1ps
// Directed bench for serial_slave_fifo: a master model drives the serial
// pins and a local model drives the FIFO ports.
module sim_serial_slave_fifo;

    localparam int W  = 8;
    localparam int HP = 8;   // serial half period in local cycles

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpol = 1'b0, cpha = 1'b0;
    logic         sclk = 1'b0, sel_n = 1'b1, sdi = 1'b0;
    logic         tx_push = 1'b0, rx_pop = 1'b0, flag_clr = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic         sdo, sdo_oe, frame_rx_pulse;
    logic [W-1:0] rx_data;
    logic [5:0]   stat;

    int checks = 0;
    int failures = 0;
    int pulse_cnt = 0;

    always #2.5 clk = ~clk;

    serial_slave_fifo #(.FRAME_W(W), .FIFO_DEPTH(4)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_cpol       (cpol),
        .cfg_cpha       (cpha),
        .sclk_in        (sclk),
        .sel_n_in       (sel_n),
        .sdi            (sdi),
        .sdo            (sdo),
        .sdo_oe         (sdo_oe),
        .tx_push        (tx_push),
        .tx_data        (tx_data),
        .rx_pop         (rx_pop),
        .rx_data        (rx_data),
        .flag_clr       (flag_clr),
        .stat           (stat),
        .frame_rx_pulse (frame_rx_pulse)
    );

    // Count received-word pulses, sampled away from the active edge.
    always @(negedge clk) if (rst_n && frame_rx_pulse) pulse_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_tx(input logic [W-1:0] w);
        @(negedge clk); tx_data = w; tx_push = 1'b1;
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic pop_rx(output logic [W-1:0] w);
        @(negedge clk); w = rx_data; rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic set_mode(input logic pol, input logic pha);
        cpol = pol; cpha = pha; sclk = pol;
        waitc(6);
    endtask

    task automatic sel_on();
        sel_n = 1'b0;
        waitc(HP);
    endtask

    task automatic sel_off();
        waitc(HP);
        sel_n = 1'b1;
        waitc(2 * HP);
    endtask

    // Master model: shifts nb bits MSB-first and returns what the slave drove.
    task automatic frame(input logic [W-1:0] mo, input int nb, output logic [W-1:0] mi);
        mi = '0;
        for (int i = W - 1; i >= W - nb; i--) begin
            if (!cpha) begin
                sdi = mo[i]; waitc(HP); mi[i] = sdo;
                sclk = !cpol; waitc(HP); sclk = cpol;
            end else begin
                sclk = !cpol; sdi = mo[i]; waitc(HP); mi[i] = sdo;
                sclk = cpol; waitc(HP);
            end
        end
    endtask

    task automatic t_reset();
        chk("R1 stat", stat, 6'b000101);
        chk("R1 oe", sdo_oe, 1'b0);
        chk("R1 sdo", sdo, 1'b0);
        chk("R1 pulse", frame_rx_pulse, 1'b0);
    endtask

    task automatic t_mode0();
        logic [W-1:0] mi, got;
        int p0;
        set_mode(1'b0, 1'b0);
        push_tx(8'hA5);
        p0 = pulse_cnt;
        sel_on();
        chk("R9 oe while selected", sdo_oe, 1'b1);
        frame(8'h3C, W, mi);
        chk("R2 miso word", mi, 8'hA5);
        chk("R2 held until select rises", stat[0], 1'b1);
        sel_off();
        chk("R9 oe after release", sdo_oe, 1'b0);
        chk("R9 sdo after release", sdo, 1'b0);
        chk("R5 one pulse", pulse_cnt - p0, 1);
        chk("R12 rx head", rx_data, 8'h3C);
        pop_rx(got);
        chk("R12 rx empty after pop", stat[0], 1'b1);
        chk("R6 no underrun", stat[4], 1'b0);
    endtask

    task automatic t_pol1();
        logic [W-1:0] mi, got;
        set_mode(1'b1, 1'b0);
        push_tx(8'h96);
        sel_on();
        frame(8'h4B, W, mi);
        sel_off();
        chk("R4 miso cpol1", mi, 8'h96);
        pop_rx(got);
        chk("R4 mosi cpol1", got, 8'h4B);
    endtask

    task automatic t_partial();
        logic [W-1:0] mi, got;
        int p0;
        set_mode(1'b0, 1'b0);
        push_tx(8'h5A);
        push_tx(8'hC3);
        p0 = pulse_cnt;
        sel_on();
        frame(8'hFF, 5, mi);
        sel_off();
        chk("R8 partial not stored", stat[0], 1'b1);
        chk("R8 no pulse", pulse_cnt - p0, 0);
        sel_on();
        frame(8'h81, W, mi);
        sel_off();
        chk("R12 tx order", mi, 8'hC3);
        pop_rx(got);
        chk("R8 restart from bit 0", got, 8'h81);
    endtask

    task automatic t_cmd_resp();
        logic [W-1:0] m0, m1, m2, m3, got;
        logic [W-1:0] cmd;
        int p0;
        cmd = 8'h9A;
        set_mode(1'b0, 1'b1);
        p0 = pulse_cnt;
        fork
            begin
                sel_on();
                frame(cmd, W, m0);
                frame(8'hFF, W, m1);
                frame(8'hFF, W, m2);
                frame(8'hFF, W, m3);
                chk("R3 select still low", sdo_oe, 1'b1);
                sel_off();
            end
            begin
                do @(negedge clk); while (!frame_rx_pulse);
                got = rx_data;
                rx_pop = 1'b1; tx_data = got + 8'd1; tx_push = 1'b1;
                @(negedge clk); rx_pop = 1'b0; tx_data = got + 8'd2;
                @(negedge clk); tx_data = got + 8'd3;
                @(negedge clk); tx_push = 1'b0;
            end
        join
        chk("R3 command received", got, cmd);
        chk("R6 underrun zeros", m0, 8'h00);
        chk("R11 reply 0", m1, cmd + 8'd1);
        chk("R11 reply 1", m2, cmd + 8'd2);
        chk("R11 reply 2", m3, cmd + 8'd3);
        chk("R3 four words received", pulse_cnt - p0, 4);
        chk("R6 stat after exchange", stat, 6'b010100);
        clear_flags();
        chk("R10 underrun cleared", stat[4], 1'b0);
        pop_rx(got); pop_rx(got); pop_rx(got);
        chk("R3 last streamed word", got, 8'hFF);
        chk("R12 rx drained", stat[0], 1'b1);
    endtask

    task automatic t_overrun();
        logic [W-1:0] mi, got;
        int p0;
        set_mode(1'b0, 1'b1);
        for (int k = 0; k < 5; k++) push_tx(8'h10 + 8'(k));
        chk("R12 tx full", stat[3], 1'b1);
        p0 = pulse_cnt;
        sel_on();
        for (int k = 0; k < 5; k++) begin
            frame(8'h20 + 8'(k), W, mi);
            chk("R12 tx word order, fifth push ignored", mi, (k < 4) ? (8'h10 + 8'(k)) : 8'h00);
        end
        sel_off();
        chk("R7 pulses only for stored words", pulse_cnt - p0, 4);
        chk("R7 stat overrun", stat, 6'b110110);
        for (int k = 0; k < 4; k++) begin
            pop_rx(got);
            chk("R7 stored words kept", got, 8'h20 + 8'(k));
        end
        chk("R7 fifth word dropped", stat[0], 1'b1);
        clear_flags();
        chk("R10 flags cleared", stat, 6'b000101);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        waitc(4);
        rst_n = 1'b1;
        waitc(4);
        t_reset();
        t_mode0();
        t_pol1();
        t_partial();
        t_cmd_resp();
        t_overrun();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule